// File: doc/BRIEF.md
# Real-Mode Address Translation Unit

This unit resolves memory accesses issued while address relocation is switched off for the access type. An instruction fetch is in real mode when the instruction-relocate bit is clear. A load or store is in real mode when the data-relocate bit is clear. Every other access is marked for the segment/page walker, which sits outside this unit, and its address is passed through unchanged.

A real-mode access starts from the effective address with its top four bits cleared. In hypervisor state, and on a core without hypervisor support, the hypervisor offset is ORed in when effective-address bit 63 is 0. In guest state there are two cases:

- When the virtualized real-mode control is set, the access is handed to the walker as a virtual-segment access. If no valid virtual segment exists, the access raises a machine check instead.
- Otherwise the access is bounded by a region limit. The limit is decoded from a 4-bit size code captured on a partition-control write. An address below the limit gets the guest offset ORed in. An address at or above it raises an instruction or data storage fault, with a syndrome that depends on the access type.

Requests use a valid/ready handshake. The result is registered and appears as a one-cycle response pulse on the cycle after acceptance.

Top module: `rmx_top`

## Requirements
- R1: A fetch (`req_kind`=0) is real-mode only when `msr_ir`=0. A load (1), store (2) or code 3 (treated as a load) is real-mode only when `msr_dr`=0. A non-real access responds with `rsp_walk`=1, `rsp_raddr` equal to the unmodified address, and no fault.
- R2: Every real-mode base address is the effective address with bits 63:60 cleared. When hypervisor state applies and bit 63 is 1, `rsp_raddr` is exactly that base.
- R3: When `msr_hv`=1 or `has_hv`=0, a real-mode access with bit 63 clear returns the base ORed with `hv_offset`.
- R4: In guest real mode with the captured virtualization control set, `vseg_valid`=1 gives `rsp_virt`=1 with `rsp_raddr` equal to the base. `vseg_valid`=0 gives `flt_mchk`=1 with `rsp_raddr` and syndrome equal to 0.
- R5: In guest real mode with the virtualization control clear, a base below the decoded limit returns the base ORed with `guest_offset`.
- R6: The size code decodes as follows: 8→32 MiB, 3→64 MiB, 7→128 MiB, 4→256 MiB, 2→1 GiB, 1→16 GiB. Every other code gives a limit of 0, so every such guest access faults. After reset the limit is 0 and the virtualization control is clear.
- R7: A guest base at or above the limit faults, and `rsp_raddr` is 0. A fetch sets `flt_isi` with syndrome 0x08000000. A load sets `flt_dsi` with syndrome 0x08000000. A store sets `flt_dsi` with syndrome 0x0A000000. `flt_dear` carries the full effective address on a data fault and is 0 otherwise.
- R8: A `pcr_wr` pulse updates the limit and the virtualization control at its clock edge. Requests accepted on later edges use the new values.
- R9: `rsp_valid` pulses for exactly one cycle after each accepted request. At most one of walk, virt, mchk, isi and dsi is set. All outcome, syndrome, address and dear outputs are 0 while `rsp_valid` is 0.
- R10: While `rst` is high, `req_ready` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| msr_ir | input | 1 | Instruction relocation enabled |
| msr_dr | input | 1 | Data relocation enabled |
| msr_hv | input | 1 | Hypervisor state |
| has_hv | input | 1 | Core implements hypervisor state |
| hv_offset | input | 64 | Hypervisor real-mode offset |
| guest_offset | input | 64 | Guest real-mode offset |
| vseg_valid | input | 1 | A valid virtual real-mode segment exists |
| pcr_wr | input | 1 | Partition-control write strobe |
| pcr_size_code | input | 4 | Guest region size code |
| pcr_virt_en | input | 1 | Virtualized real-mode control |
| rsp_valid | output | 1 | Response pulse |
| rsp_raddr | output | 64 | Real address |
| rsp_walk | output | 1 | Relocation on: send to walker |
| rsp_virt | output | 1 | Virtual-segment real-mode path |
| flt_mchk | output | 1 | Machine check |
| flt_isi | output | 1 | Instruction storage fault |
| flt_dsi | output | 1 | Data storage fault |
| flt_syndrome | output | 32 | Fault syndrome |
| flt_dear | output | 64 | Faulting data address |

## Verification
A wrongly held limit or virtualization control shows up at the ports as a guest access that faults or passes on the wrong side of a size boundary. It is visible on the response to the first guest access after the corrupting write. The bench probes each size code just below and exactly at its limit. A wrong path choice shows up within one response, as a wrong outcome flag or an offset applied when bit 63 says it must not be.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  localparam logic [31:0] SYN_BOUND = 32'h0800_0000;
  localparam logic [31:0] SYN_STORE = 32'h0200_0000;

  typedef struct packed {
    logic walk;
    logic virt;
    logic mchk;
    logic isi;
    logic dsi;
  } outcome_t;
endpackage

// File: rtl/rmx_limit_reg.sv
module rmx_limit_reg #(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  input  logic              virt_in,
  output logic [ADDR_W-1:0] limit,
  output logic              virt_en
);
  function automatic logic [ADDR_W-1:0] size_of(input logic [CODE_W-1:0] c);
    logic [ADDR_W-1:0] one;
    one = ADDR_W'(1);
    case (c)
      CODE_W'(8): size_of = one << 25;
      CODE_W'(3): size_of = one << 26;
      CODE_W'(7): size_of = one << 27;
      CODE_W'(4): size_of = one << 28;
      CODE_W'(2): size_of = one << 30;
      CODE_W'(1): size_of = one << 34;
      default:    size_of = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      limit   <= '0;
      virt_en <= 1'b0;
    end else if (wr) begin
      limit   <= size_of(code);
      virt_en <= virt_in;
    end
  end
endmodule

// File: rtl/rmx_resolve.sv
module rmx_resolve
  import rmx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IGN_W  = 4
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        kind,
  input  logic              ir,
  input  logic              dr,
  input  logic              hv,
  input  logic              has_hv,
  input  logic [ADDR_W-1:0] hv_off,
  input  logic [ADDR_W-1:0] g_off,
  input  logic              vseg_ok,
  input  logic [ADDR_W-1:0] limit,
  input  logic              virt_en,
  output outcome_t          oc,
  output logic [ADDR_W-1:0] raddr,
  output logic [31:0]       syn,
  output logic [ADDR_W-1:0] dear
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = {{IGN_W{1'b0}}, {(ADDR_W-IGN_W){1'b1}}};

  logic [ADDR_W-1:0] base;
  logic              is_fetch;
  logic              is_store;
  logic              real_mode;

  always_comb begin
    base      = ea & KEEP_MASK;
    is_fetch  = (kind_e'(kind) == KIND_FETCH);
    is_store  = (kind_e'(kind) == KIND_STORE);
    real_mode = is_fetch ? !ir : !dr;
    oc        = '0;
    raddr     = '0;
    syn       = '0;
    dear      = '0;
    if (!real_mode) begin
      oc.walk = 1'b1;
      raddr   = ea;
    end else if (hv || !has_hv) begin
      raddr = ea[ADDR_W-1] ? base : (base | hv_off);
    end else if (virt_en) begin
      if (vseg_ok) begin
        oc.virt = 1'b1;
        raddr   = base;
      end else begin
        oc.mchk = 1'b1;
      end
    end else if (base < limit) begin
      raddr = base | g_off;
    end else if (is_fetch) begin
      oc.isi = 1'b1;
      syn    = SYN_BOUND;
    end else begin
      oc.dsi = 1'b1;
      syn    = is_store ? (SYN_BOUND | SYN_STORE) : SYN_BOUND;
      dear   = ea;
    end
  end
endmodule

// File: rtl/rmx_top.sv
module rmx_top
  import rmx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 4,
  parameter int IGN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [1:0]        req_kind,
  input  logic              msr_ir,
  input  logic              msr_dr,
  input  logic              msr_hv,
  input  logic              has_hv,
  input  logic [ADDR_W-1:0] hv_offset,
  input  logic [ADDR_W-1:0] guest_offset,
  input  logic              vseg_valid,
  input  logic              pcr_wr,
  input  logic [CODE_W-1:0] pcr_size_code,
  input  logic              pcr_virt_en,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_raddr,
  output logic              rsp_walk,
  output logic              rsp_virt,
  output logic              flt_mchk,
  output logic              flt_isi,
  output logic              flt_dsi,
  output logic [31:0]       flt_syndrome,
  output logic [ADDR_W-1:0] flt_dear
);
  logic [ADDR_W-1:0] limit;
  logic              virt_en;
  outcome_t          oc_c;
  logic [ADDR_W-1:0] raddr_c;
  logic [31:0]       syn_c;
  logic [ADDR_W-1:0] dear_c;
  logic              accept;

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  rmx_limit_reg #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_limit (
    .clk(clk), .rst(rst), .wr(pcr_wr), .code(pcr_size_code),
    .virt_in(pcr_virt_en), .limit(limit), .virt_en(virt_en)
  );

  rmx_resolve #(.ADDR_W(ADDR_W), .IGN_W(IGN_W)) u_resolve (
    .ea(req_ea), .kind(req_kind), .ir(msr_ir), .dr(msr_dr),
    .hv(msr_hv), .has_hv(has_hv), .hv_off(hv_offset), .g_off(guest_offset),
    .vseg_ok(vseg_valid), .limit(limit), .virt_en(virt_en),
    .oc(oc_c), .raddr(raddr_c), .syn(syn_c), .dear(dear_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !accept) begin
      rsp_valid    <= 1'b0;
      rsp_raddr    <= '0;
      rsp_walk     <= 1'b0;
      rsp_virt     <= 1'b0;
      flt_mchk     <= 1'b0;
      flt_isi      <= 1'b0;
      flt_dsi      <= 1'b0;
      flt_syndrome <= '0;
      flt_dear     <= '0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_raddr    <= raddr_c;
      rsp_walk     <= oc_c.walk;
      rsp_virt     <= oc_c.virt;
      flt_mchk     <= oc_c.mchk;
      flt_isi      <= oc_c.isi;
      flt_dsi      <= oc_c.dsi;
      flt_syndrome <= syn_c;
      flt_dear     <= dear_c;
    end
  end
endmodule

// File: rtl/rmx_checker.sv
module rmx_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_raddr,
  input logic              rsp_walk,
  input logic              rsp_virt,
  input logic              flt_mchk,
  input logic              flt_isi,
  input logic              flt_dsi,
  input logic [31:0]       flt_syndrome,
  input logic [ADDR_W-1:0] flt_dear
);
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_walk, rsp_virt, flt_mchk, flt_isi, flt_dsi})); // R9
  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_raddr == '0 && flt_syndrome == '0 && flt_dear == '0
                    && !rsp_walk && !rsp_virt && !flt_mchk && !flt_isi && !flt_dsi)); // R9
  AST_ISI_SYNDROME: assert property (@(posedge clk) disable iff (rst)
    flt_isi |-> (flt_syndrome == 32'h0800_0000 && $past(req_kind) == 2'd0)); // R7
  AST_DSI_STORE_BIT: assert property (@(posedge clk) disable iff (rst)
    flt_dsi |-> (flt_syndrome[27] && (flt_syndrome[25] == ($past(req_kind) == 2'd2)))); // R7
  AST_MCHK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    flt_mchk |-> (flt_syndrome == '0 && rsp_raddr == '0)); // R4
  AST_NOT_READY_IN_RESET: assert property (@(posedge clk)
    rst |-> !req_ready); // R10
endmodule

bind rmx_top rmx_checker #(.ADDR_W(ADDR_W)) u_rmx_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_raddr(rsp_raddr),
  .rsp_walk(rsp_walk), .rsp_virt(rsp_virt), .flt_mchk(flt_mchk),
  .flt_isi(flt_isi), .flt_dsi(flt_dsi), .flt_syndrome(flt_syndrome),
  .flt_dear(flt_dear)
);

// File: tb/tb_rmx_top.sv
module tb_rmx_top;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 5 + 32 + 64 + 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        msr_ir = 1'b0, msr_dr = 1'b0, msr_hv = 1'b0, has_hv = 1'b1;
  logic [63:0] hv_offset = '0, guest_offset = '0;
  logic        vseg_valid = 1'b0;
  logic        pcr_wr = 1'b0;
  logic [3:0]  pcr_size_code = '0;
  logic        pcr_virt_en = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_raddr;
  logic        rsp_walk, rsp_virt, flt_mchk, flt_isi, flt_dsi;
  logic [31:0] flt_syndrome;
  logic [63:0] flt_dear;

  logic [3:0]  cur_code = '0;
  logic        cur_virt = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmx_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_kind(req_kind), .msr_ir(msr_ir), .msr_dr(msr_dr),
    .msr_hv(msr_hv), .has_hv(has_hv), .hv_offset(hv_offset),
    .guest_offset(guest_offset), .vseg_valid(vseg_valid), .pcr_wr(pcr_wr),
    .pcr_size_code(pcr_size_code), .pcr_virt_en(pcr_virt_en),
    .rsp_valid(rsp_valid), .rsp_raddr(rsp_raddr), .rsp_walk(rsp_walk),
    .rsp_virt(rsp_virt), .flt_mchk(flt_mchk), .flt_isi(flt_isi),
    .flt_dsi(flt_dsi), .flt_syndrome(flt_syndrome), .flt_dear(flt_dear)
  );

  function automatic logic [63:0] lim_of(input logic [3:0] c);
    case (c)
      4'h8: return 64'h0000_0000_0200_0000;
      4'h3: return 64'h0000_0000_0400_0000;
      4'h7: return 64'h0000_0000_0800_0000;
      4'h4: return 64'h0000_0000_1000_0000;
      4'h2: return 64'h0000_0000_4000_0000;
      4'h1: return 64'h0000_0004_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  // expected {walk,virt,mchk,isi,dsi,syndrome,dear,raddr}
  function automatic logic [OW-1:0] model();
    logic [63:0] b;
    logic        fetch, realm;
    b     = {4'h0, req_ea[59:0]};
    fetch = (req_kind == 2'd0);
    realm = fetch ? !msr_ir : !msr_dr;
    if (!realm) return {5'b10000, 32'h0, 64'h0, req_ea};
    if (msr_hv || !has_hv) return {5'b00000, 32'h0, 64'h0, req_ea[63] ? b : (b | hv_offset)};
    if (cur_virt) begin
      if (vseg_valid) return {5'b01000, 32'h0, 64'h0, b};
      return {5'b00100, 32'h0, 64'h0, 64'h0};
    end
    if (b < lim_of(cur_code)) return {5'b00000, 32'h0, 64'h0, b | guest_offset};
    if (fetch) return {5'b00010, 32'h0800_0000, 64'h0, 64'h0};
    return {5'b00001, (req_kind == 2'd2) ? 32'h0A00_0000 : 32'h0800_0000, req_ea, 64'h0};
  endfunction

  function automatic string tag_of(input logic [OW-1:0] e);
    if (e[OW-1]) return "R1";
    if (e[OW-2] || e[OW-3]) return "R4";
    if (e[OW-4] || e[OW-5]) return "R7";
    if (msr_hv || !has_hv) return "R3";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [OW-1:0] got, input logic [OW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h ea=%h kind=%0d", tag, got, exp, req_ea, req_kind);
    end
  endtask

  task automatic pcr_write(input logic [3:0] c, input logic v);
    pcr_wr = 1'b1; pcr_size_code = c; pcr_virt_en = v;
    @(negedge clk);
    pcr_wr = 1'b0;
    cur_code = c; cur_virt = v;
  endtask

  task automatic apply(input string tag);
    logic [OW-1:0] e;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    e = model();
    chk((tag == "") ? tag_of(e) : tag, {1'b1, rsp_walk, rsp_virt, flt_mchk, flt_isi, flt_dsi,
        flt_syndrome, flt_dear, rsp_raddr}, {1'b1, e} & {rsp_valid, {OW{1'b1}}});
    if (rsp_valid !== 1'b1) chk("R9", {OW{1'b0}}, {OW{1'b1}});
  endtask

  task automatic set_mode(input logic ir, input logic dr, input logic hv, input logic hh);
    msr_ir = ir; msr_dr = dr; msr_hv = hv; has_hv = hh;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    hv_offset    = 64'h0000_0100_0000_0000;
    guest_offset = 64'h0000_0200_0000_0000;
    repeat (3) @(negedge clk);
    // R10: held in reset
    chk("R10", {OW{1'b0}} | {req_ready, rsp_valid}, {OW{1'b0}});
    rst = 1'b0;
    @(negedge clk);

    // R6 / R10: after reset limit is 0, guest load faults
    set_mode(0, 0, 0, 1); req_kind = 2'd1; req_ea = 64'h10; apply("R6");

    // R1: relocation selects per access type
    set_mode(1, 0, 0, 1); req_kind = 2'd0; req_ea = 64'hF000_0000_1234_5678; apply("R1");
    set_mode(0, 1, 1, 1); req_kind = 2'd2; req_ea = 64'h8000_0000_0000_0040; apply("R1");
    set_mode(0, 1, 1, 1); req_kind = 2'd0; req_ea = 64'h0000_0000_0000_0040; apply("R1");
    set_mode(1, 0, 1, 1); req_kind = 2'd3; req_ea = 64'h0000_0000_0000_0080; apply("R1");

    // R2 / R3: hypervisor offset and bit 63
    set_mode(0, 0, 1, 1); req_kind = 2'd1; req_ea = 64'hF123_4567_89AB_CDEF; apply("R2");
    req_ea = 64'h7123_4567_89AB_CDEF; apply("R2");
    req_ea = 64'h0000_0000_00AB_CDE0; apply("R3");
    set_mode(0, 0, 0, 0); req_ea = 64'h0000_0000_0000_1000; apply("R3");

    // R6: each code probed just below and at its limit
    set_mode(0, 0, 0, 1);
    for (int c = 0; c < 16; c++) begin
      pcr_write(4'(c), 1'b0);
      req_kind = 2'd1;
      if (lim_of(4'(c)) != 64'h0) begin
        req_ea = lim_of(4'(c)) - 64'h1; apply("R6");
      end
      req_ea = lim_of(4'(c)); apply("R6");
    end

    // R7: fault syndromes per type
    pcr_write(4'h8, 1'b0);
    req_ea = 64'h0000_0000_0300_0000;
    req_kind = 2'd0; apply("R7");
    req_kind = 2'd1; apply("R7");
    req_kind = 2'd2; apply("R7");
    req_ea = 64'hF000_0000_0000_0000 | 64'h0400_0000; req_kind = 2'd2; apply("R7");

    // R8: rewrite takes effect for the next request
    req_kind = 2'd1; req_ea = 64'h0000_0000_0200_0000; apply("R8");
    pcr_write(4'h1, 1'b0); apply("R8");

    // R4: virtual segment path
    pcr_write(4'h1, 1'b1);
    vseg_valid = 1'b1; req_ea = 64'hA000_0000_0000_5000; apply("R4");
    vseg_valid = 1'b0; apply("R4");

    // R9: the pulse lasts one cycle
    @(negedge clk);
    chk("R9", {{(OW-1){1'b0}}, rsp_valid}, {OW{1'b0}});

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        pcr_write(4'($urandom_range(0, 15)), 1'($urandom_range(0, 3) == 0));
      end
      set_mode(1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
               1'($urandom_range(0, 7) != 0));
      vseg_valid = 1'($urandom);
      req_kind   = 2'($urandom_range(0, 3));
      req_ea     = {32'($urandom), 32'($urandom)};
      if ($urandom_range(0, 1) == 1) req_ea = req_ea & 64'h0000_0007_FFFF_FFFF;
      if ($urandom_range(0, 3) == 0) req_ea[63] = 1'b1;
      apply("");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule